// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Synchronizer Depth

This block passes data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Each side has its own clock and its own synchronous reset. Each side also has its own full flag, empty flag and count of stored words. The write and read positions move between the domains as Gray-coded values through a synchronizer chain. The depth of that chain, called N here, is a parameter.

Every status output changes in a fixed cycle. Local events show up after a fixed number of local-clock edges. Events from the other side show up after a fixed number of the other clock's edges plus N local edges. Each count takes one local edge more than the flags on the same side.

The read port works in one of two modes. In normal mode the output register loads a word only when a read is accepted. In show-ahead mode the output register always holds the word at the head of the queue.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, both empty flags are 1, both full flags are 0, both counts are 0, and in normal mode `rd_data` is 0.
- R2: An accepted write changes `wr_empty` and `wr_full` after the first write-clock edge that samples it.
- R3: `wr_used` reflects an accepted write after the second write-clock edge.
- R4: `rd_empty` and `rd_full` reflect a write two write-clock edges after it, followed by N read-clock edges. The positions cross the domains as Gray codes, so a position changes by at most one bit per clock.
- R5: `rd_used` reflects a write two write-clock edges after it, followed by N+1 read-clock edges.
- R6: An accepted read changes `rd_empty` and `rd_full` after the first read-clock edge that samples it.
- R7: `rd_used` reflects an accepted read after the second read-clock edge.
- R8: `wr_empty` and `wr_full` reflect a read one read-clock edge after it, followed by N write-clock edges. `wr_used` reflects it after N+1 write-clock edges.
- R9: In normal mode, `rd_data` takes the oldest stored word on the read-clock edge that accepts a read, so words leave in the order they were written.
- R10: In show-ahead mode, `rd_data` shows the head word without any read. A word written into an empty queue appears one write-clock edge plus one read-clock edge after the write. After an accepted read, the next word appears one read-clock edge later.
- R11: A write while `wr_full` is 1 is ignored: it changes neither the stored words nor the counts.
- R12: A read while `rd_empty` is 1 is ignored: it changes neither `rd_data` (in normal mode), the read position nor the counts.
- R13: When 2^ADDR_W words are stored and both sides have settled, `wr_full` and `rd_full` are both 1 and both counts equal 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Queue full, write-side view |
| wr_empty | output | 1 | Queue empty, write-side view |
| wr_used | output | ADDR_W+1 | Stored words, write-side view |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Output word register |
| rd_full | output | 1 | Queue full, read-side view |
| rd_empty | output | 1 | Queue empty, read-side view |
| rd_used | output | ADDR_W+1 | Stored words, read-side view |

## Verification
The write-side flags are due one write edge after a write, and `wr_used` is due one write edge after that. On the read side the flags are due N read edges after the second write edge, and `rd_used` one read edge later. Reads mirror this with the clocks swapped. The bench counts those edges itself. It samples two nanoseconds after each edge of interest, and it checks both that a result has not yet changed one edge early and that it has changed on the edge it is due. When a read's effects must be timed in both domains at once, a fork follows the two clocks in parallel. The table-driven part only compares values after both sides have settled.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  typedef enum logic [0:0] {
    RM_NORMAL    = 1'b0,
    RM_SHOWAHEAD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W = 4,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] pre,
  output logic [W-1:0] last
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign pre  = stg[N-2];
  assign last = stg[N-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= ram[raddr];
  end
endmodule

// File: rtl/xclk_fifo_wctl.sv
module xclk_fifo_wctl #(
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_pre,
  input  logic [AW:0]   rgray_last,
  output logic          wr_ok,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_full,
  output logic          wr_empty,
  output logic [AW:0]   wr_used
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nxt, rpre_bin, rlast_bin;

  assign rpre_bin  = g2b(rgray_pre);
  assign rlast_bin = g2b(rgray_last);
  assign wr_ok     = wr_req & ~wr_full;
  assign wbin_nxt  = wbin + PW'(wr_ok);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin     <= '0;
      wgray    <= '0;
      wr_full  <= 1'b0;
      wr_empty <= 1'b1;
      wr_used  <= '0;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= wbin ^ (wbin >> 1);
      wr_full  <= (wbin_nxt - rpre_bin) == DEPTH;
      wr_empty <= wbin_nxt == rpre_bin;
      wr_used  <= wbin - rlast_bin;
    end
  end

  // R11
  overflow_ign_chk: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && wr_full) |=> $stable(wbin));

  // R4
  wgray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R13
  wr_used_bound_chk: assert property (@(posedge wclk) disable iff (wrst)
    wr_used <= DEPTH);
endmodule

// File: rtl/xclk_fifo_rctl.sv
module xclk_fifo_rctl
  import xclk_fifo_pkg::*;
#(
  parameter int       AW      = 3,
  parameter rd_mode_e RD_MODE = RM_NORMAL
) (
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_pre,
  input  logic [AW:0]   wgray_last,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic          rd_full,
  output logic          rd_empty,
  output logic [AW:0]   rd_used
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rd_ok;
  logic [PW-1:0] rbin, rbin_nxt, wpre_bin, wlast_bin;

  assign wpre_bin  = g2b(wgray_pre);
  assign wlast_bin = g2b(wgray_last);
  assign rd_ok     = rd_req & ~rd_empty;
  assign rbin_nxt  = rbin + PW'(rd_ok);

  generate
    if (RD_MODE == RM_SHOWAHEAD) begin : g_ahead
      assign mem_re    = 1'b1;
      assign mem_raddr = rbin_nxt[AW-1:0];
    end else begin : g_normal
      assign mem_re    = rd_ok;
      assign mem_raddr = rbin[AW-1:0];
    end
  endgenerate

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_full  <= 1'b0;
      rd_empty <= 1'b1;
      rd_used  <= '0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
      rd_empty <= rbin_nxt == wpre_bin;
      rd_full  <= (wpre_bin - rbin_nxt) == DEPTH;
      rd_used  <= wlast_bin - rbin;
    end
  end

  // R12
  underflow_ign_chk: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && rd_empty) |=> $stable(rbin));

  // R9
  rd_step_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_ok |=> (rbin == $past(rbin) + PW'(1)));

  // R4
  rgray_step_chk: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R13
  rd_used_bound_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_used <= DEPTH);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int       DATA_W  = 8,
  parameter int       ADDR_W  = 3,
  parameter int       SYNC_N  = 2,
  parameter rd_mode_e RD_MODE = RM_NORMAL
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_empty,
  output logic [ADDR_W:0]   wr_used,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_full,
  output logic              rd_empty,
  output logic [ADDR_W:0]   rd_used
);
  localparam int PW = ADDR_W + 1;

  logic              wr_ok, mem_re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray;
  logic [PW-1:0]     wg_pre, wg_last, rg_pre, rg_last;

  xclk_fifo_wctl #(.AW(ADDR_W)) u_wctl (
    .wclk(wr_clk), .wrst(wr_rst), .wr_req(wr_req),
    .rgray_pre(rg_pre), .rgray_last(rg_last),
    .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray),
    .wr_full(wr_full), .wr_empty(wr_empty), .wr_used(wr_used)
  );

  xclk_fifo_sync #(.W(PW), .N(SYNC_N)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .pre(wg_pre), .last(wg_last)
  );

  xclk_fifo_sync #(.W(PW), .N(SYNC_N)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .pre(rg_pre), .last(rg_last)
  );

  xclk_fifo_rctl #(.AW(ADDR_W), .RD_MODE(RD_MODE)) u_rctl (
    .rclk(rd_clk), .rrst(rd_rst), .rd_req(rd_req),
    .wgray_pre(wg_pre), .wgray_last(wg_last),
    .mem_re(mem_re), .mem_raddr(raddr), .rgray(rgray),
    .rd_full(rd_full), .rd_empty(rd_empty), .rd_used(rd_used)
  );

  xclk_fifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(mem_re), .raddr(raddr), .q(rd_data)
  );
endmodule

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;
  import xclk_fifo_pkg::*;

  localparam int DW = 8;
  localparam int AW = 3;
  localparam int SYNC_N = 2;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 10;
  // {pop, data or expected word, expected settled count}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 8'h11, 4'd1}, {1'b0, 8'h22, 4'd2}, {1'b1, 8'h11, 4'd1},
    {1'b0, 8'h33, 4'd2}, {1'b0, 8'h44, 4'd3}, {1'b1, 8'h22, 4'd2},
    {1'b1, 8'h33, 4'd1}, {1'b0, 8'h55, 4'd2}, {1'b1, 8'h44, 4'd1},
    {1'b1, 8'h55, 4'd0}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic n_wr_req = 0, n_rd_req = 0, s_wr_req = 0, s_rd_req = 0;
  logic [DW-1:0] n_wr_data = '0, s_wr_data = '0, n_rd_data, s_rd_data;
  logic n_wr_full, n_wr_empty, n_rd_full, n_rd_empty;
  logic s_wr_full, s_wr_empty, s_rd_full, s_rd_empty;
  logic [AW:0] n_wr_used, n_rd_used, s_wr_used, s_rd_used;
  int checks = 0, errors = 0;

  always #10 wr_clk = ~wr_clk;
  initial begin #7; forever #10 rd_clk = ~rd_clk; end

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_N(SYNC_N), .RD_MODE(RM_NORMAL)) u_xclk_fifo (
    .wr_clk(wr_clk), .wr_rst(rst), .wr_req(n_wr_req), .wr_data(n_wr_data),
    .wr_full(n_wr_full), .wr_empty(n_wr_empty), .wr_used(n_wr_used),
    .rd_clk(rd_clk), .rd_rst(rst), .rd_req(n_rd_req), .rd_data(n_rd_data),
    .rd_full(n_rd_full), .rd_empty(n_rd_empty), .rd_used(n_rd_used));

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_N(SYNC_N), .RD_MODE(RM_SHOWAHEAD)) u_xclk_fifo_sa (
    .wr_clk(wr_clk), .wr_rst(rst), .wr_req(s_wr_req), .wr_data(s_wr_data),
    .wr_full(s_wr_full), .wr_empty(s_wr_empty), .wr_used(s_wr_used),
    .rd_clk(rd_clk), .rd_rst(rst), .rd_req(s_rd_req), .rd_data(s_rd_data),
    .rd_full(s_rd_full), .rd_empty(s_rd_empty), .rd_used(s_rd_used));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (SYNC_N + 5) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic n_push(input logic [DW-1:0] d);
    @(negedge wr_clk); n_wr_req = 1'b1; n_wr_data = d;
    @(negedge wr_clk); n_wr_req = 1'b0;
  endtask

  task automatic n_pop();
    @(negedge rd_clk); n_rd_req = 1'b1;
    @(negedge rd_clk); n_rd_req = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (6) @(posedge wr_clk);
    @(negedge wr_clk); rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 wr_empty", n_wr_empty, 1); chk("R1 rd_empty", n_rd_empty, 1);
    chk("R1 wr_full", n_wr_full, 0);   chk("R1 rd_full", n_rd_full, 0);
    chk("R1 wr_used", n_wr_used, 0);   chk("R1 rd_used", n_rd_used, 0);
    chk("R1 rd_data", n_rd_data, 0);

    // table of settled push/pop steps, normal mode
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][12]) begin
        n_pop();
        chk("R9 order", n_rd_data, VEC[i][11:4]);
      end else begin
        n_push(VEC[i][11:4]);
      end
      settle();
      chk("R3 wr_used settled", n_wr_used, VEC[i][3:0]);
      chk("R5 rd_used settled", n_rd_used, VEC[i][3:0]);
      chk("R4 rd_empty settled", n_rd_empty, VEC[i][3:0] == 0);
    end

    // write latency
    @(negedge wr_clk); n_wr_req = 1'b1; n_wr_data = 8'h3C;
    @(posedge wr_clk); #2 n_wr_req = 1'b0;
    chk("R2 wr_empty after 1 wclk", n_wr_empty, 0);
    chk("R3 wr_used not after 1 wclk", n_wr_used, 0);
    @(posedge wr_clk); #2;
    chk("R3 wr_used after 2 wclk", n_wr_used, 1);
    for (int k = 1; k < SYNC_N; k++) begin
      @(posedge rd_clk); #2;
      chk("R4 rd_empty early", n_rd_empty, 1);
    end
    @(posedge rd_clk); #2;
    chk("R4 rd_empty after N rclk", n_rd_empty, 0);
    chk("R5 rd_used early", n_rd_used, 0);
    @(posedge rd_clk); #2;
    chk("R5 rd_used after N+1 rclk", n_rd_used, 1);
    settle();

    // read latency, both domains in parallel
    @(negedge rd_clk); n_rd_req = 1'b1;
    @(posedge rd_clk); #2 n_rd_req = 1'b0;
    chk("R6 rd_empty after 1 rclk", n_rd_empty, 1);
    chk("R9 rd_data after 1 rclk", n_rd_data, 8'h3C);
    chk("R7 rd_used early", n_rd_used, 1);
    fork
      begin
        @(posedge rd_clk); #2;
        chk("R7 rd_used after 2 rclk", n_rd_used, 0);
      end
      begin
        for (int k = 1; k < SYNC_N; k++) begin
          @(posedge wr_clk); #2;
          chk("R8 wr_empty early", n_wr_empty, 0);
        end
        @(posedge wr_clk); #2;
        chk("R8 wr_empty after N wclk", n_wr_empty, 1);
        chk("R8 wr_used early", n_wr_used, 1);
        @(posedge wr_clk); #2;
        chk("R8 wr_used after N+1 wclk", n_wr_used, 0);
      end
    join
    settle();

    // fill to full, then one write past full
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wr_clk); n_wr_req = 1'b1; n_wr_data = DW'(8'h80 + i);
      @(posedge wr_clk); #2;
      chk("R2 wr_full on last word", n_wr_full, i == DEPTH - 1);
    end
    @(negedge wr_clk); n_wr_data = 8'hEE;
    @(negedge wr_clk); n_wr_req = 1'b0;
    settle();
    chk("R11 wr_used after overflow", n_wr_used, DEPTH);
    chk("R13 rd_full", n_rd_full, 1); chk("R13 wr_full", n_wr_full, 1);
    chk("R13 rd_used", n_rd_used, DEPTH);

    // drain, then one read past empty
    @(negedge rd_clk); n_rd_req = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(posedge rd_clk); #2;
      chk("R9 drain order", n_rd_data, 8'h80 + i);
      if (i == 0) chk("R6 rd_full after 1 rclk", n_rd_full, 0);
    end
    chk("R11 no extra word", n_rd_empty, 1);
    @(posedge rd_clk); #2 n_rd_req = 1'b0;
    chk("R12 rd_data held", n_rd_data, 8'h87);
    settle();
    chk("R12 rd_used", n_rd_used, 0); chk("R11 wr_used", n_wr_used, 0);
    n_push(8'h77);
    settle();
    n_pop();
    chk("R12 read pointer not moved", n_rd_data, 8'h77);

    // show-ahead mode
    @(negedge wr_clk); s_wr_req = 1'b1; s_wr_data = 8'h5A;
    @(posedge wr_clk); #2 s_wr_req = 1'b0;
    @(posedge rd_clk); #2;
    chk("R10 word at output 1 wclk + 1 rclk", s_rd_data, 8'h5A);
    @(negedge wr_clk); s_wr_req = 1'b1; s_wr_data = 8'h6B;
    @(negedge wr_clk); s_wr_req = 1'b0;
    settle();
    chk("R10 head held without read", s_rd_data, 8'h5A);
    @(negedge rd_clk); s_rd_req = 1'b1;
    @(posedge rd_clk); #2 s_rd_req = 1'b0;
    chk("R10 next word after read", s_rd_data, 8'h6B);
    @(negedge rd_clk); s_rd_req = 1'b1;
    @(posedge rd_clk); #2 s_rd_req = 1'b0;
    chk("R6 show-ahead empty after last read", s_rd_empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule